// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This block is the power manager of a small microcontroller. The core issues a sleep instruction as a one-cycle pulse. If the sleep-enable bit is set at that moment, the block reads a 3-bit mode field. It then moves to a sleep state that removes the enables of a chosen set of clock domains: CPU, I/O, non-volatile memory, ADC and oscillator. Each sleep state accepts its own set of wake events. When one of them arrives, the block restores the clocks, either on the next cycle or after a programmable oscillator start-up wait.

A per-peripheral power reduction vector removes individual peripheral clocks while the part is active or idle. While a peripheral's clock is removed, the block also blocks register accesses to that peripheral. Entering the ADC noise-reduction mode sends a one-cycle conversion start to the ADC. Power-down forces the analog comparator enable off.

States are `ST_ACTIVE`, `ST_IDLE`, `ST_ADCNR`, `ST_PDOWN`, `ST_STBY` and `ST_OSCWAIT`. The transitions are:

- **enter**: `ST_ACTIVE` goes to the state that `mode_sel` names, on `sleep_pulse` with `sleep_en`.
- **wake-fast**: `ST_IDLE`, `ST_ADCNR` and `ST_STBY` go to `ST_ACTIVE` on an allowed wake event.
- **wake-slow**: `ST_PDOWN` goes to `ST_OSCWAIT` on an allowed wake event.
- **osc-ready**: `ST_OSCWAIT` goes to `ST_ACTIVE` when the start-up count expires.

Top module: `slpc_ctrl`

## Requirements
- R1: After reset the block is active. `cpu_clk_en`, `io_clk_en`, `nvm_clk_en`, `adc_clk_en` and `osc_en` are high and `asleep` is low.
- R2: Mode 3'b000 (idle) turns off the CPU and NVM clock enables and keeps I/O, ADC and oscillator on. Any of the five wake inputs, `wake_other` included, returns the block to active on the next cycle.
- R3: Mode 3'b001 (ADC noise reduction) turns off CPU, I/O and NVM and keeps ADC and oscillator on. On entry `adc_start` is high for exactly one cycle (the first cycle in the mode) if `adc_enabled` was high, and stays low otherwise.
- R4: In noise reduction, `wake_wdt`, `wake_ext`, `wake_pcint` and `wake_adc` wake the block on the next cycle. `wake_other` is ignored.
- R5: Mode 3'b010 (power-down) turns off every clock enable, `osc_en` included.
- R6: In power-down only `wake_wdt`, `wake_ext` and `wake_pcint` are accepted. `wake_adc` and `wake_other` leave all enables off.
- R7: A power-down wake first raises `osc_en` alone for OSC_START cycles (default 16) and only then restores the other clock enables.
- R8: Mode 3'b100 (standby) matches power-down with `osc_en` kept high. An accepted wake restores all clocks on the next cycle.
- R9: A sleep pulse has no effect in any of these cases: `sleep_en` is low, the mode is 3'b011, 3'b101, 3'b110 or 3'b111, or the block is already asleep.
- R10: Bit i of `prr` controls peripheral i, the peripheral selected by `bus_sel` = i. While the bit is set, `periph_clk_en[i]` is low, `periph_wr[i]` stays low on writes, and `bus_rdata` reads zero. Clearing the bit restores the clock and access.
- R11: `prr` gates peripheral clocks only in active and idle. In every other state all `periph_clk_en` bits are low.
- R12: `acomp_en` follows `acomp_req`, except that it is forced low in power-down and during the oscillator start-up wait that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_en | input | 1 | Sleep enable bit |
| sleep_pulse | input | 1 | One-cycle sleep instruction pulse |
| mode_sel | input | 3 | Sleep mode select |
| wake_wdt | input | 1 | Watchdog wake event |
| wake_ext | input | 1 | External level interrupt |
| wake_pcint | input | 1 | Pin-change interrupt |
| wake_adc | input | 1 | ADC conversion complete |
| wake_other | input | 1 | Any other enabled interrupt |
| adc_enabled | input | 1 | ADC is enabled |
| acomp_req | input | 1 | Software analog comparator enable |
| prr | input | NPERIPH | Power reduction bits, one per peripheral |
| bus_sel | input | SEL_W | Peripheral selected for register access |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| periph_rdata | input | NPERIPH*DW | Read data from each peripheral, peripheral i at bits i*DW |
| cpu_clk_en | output | 1 | CPU clock enable |
| io_clk_en | output | 1 | I/O clock enable |
| nvm_clk_en | output | 1 | NVM clock enable |
| adc_clk_en | output | 1 | ADC clock enable |
| osc_en | output | 1 | Oscillator enable |
| acomp_en | output | 1 | Analog comparator enable |
| adc_start | output | 1 | One-cycle conversion start request |
| periph_clk_en | output | NPERIPH | Per-peripheral clock enables |
| periph_wr | output | NPERIPH | Per-peripheral write strobes after blocking |
| bus_rdata | output | DW | Read data after blocking |
| asleep | output | 1 | High whenever not in the active state |

## Verification
The assertions cover the invariants that hold on every cycle:
- the CPU never runs without the oscillator;
- a start request is a single cycle and occurs only with the ADC clock on and the CPU stopped;
- a peripheral write never passes while that peripheral's clock is off;
- a power-down that sees no accepted wake event stays dark.

The mode-specific wake filters, the exact length of the oscillator wait, and the read-zero and write-drop behaviour on gated peripherals can only be shown by the bench. So can resumption after a power reduction bit is cleared. The bench shows these by driving each mode with accepted and rejected events and comparing the outputs in the predicted cycle.

// File: rtl/slpc_pkg.sv
package slpc_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE  = 3'd0,
        ST_IDLE    = 3'd1,
        ST_ADCNR   = 3'd2,
        ST_PDOWN   = 3'd3,
        ST_STBY    = 3'd4,
        ST_OSCWAIT = 3'd5
    } slpc_state_e;

    localparam logic [2:0] MODE_IDLE  = 3'b000;
    localparam logic [2:0] MODE_ADCNR = 3'b001;
    localparam logic [2:0] MODE_PDOWN = 3'b010;
    localparam logic [2:0] MODE_STBY  = 3'b100;

    // Wake source vector layout
    localparam int WK_WDT   = 0;
    localparam int WK_EXT   = 1;
    localparam int WK_PCINT = 2;
    localparam int WK_ADC   = 3;
    localparam int WK_OTHER = 4;
    localparam int WK_N     = 5;

endpackage

// File: rtl/slpc_mode_decode.sv
module slpc_mode_decode
    import slpc_pkg::*;
(
    input  logic [2:0]  mode_sel,
    output logic        mode_ok,
    output slpc_state_e mode_state
);
    always_comb begin
        mode_ok    = 1'b1;
        mode_state = ST_ACTIVE;
        unique case (mode_sel)
            MODE_IDLE:  mode_state = ST_IDLE;
            MODE_ADCNR: mode_state = ST_ADCNR;
            MODE_PDOWN: mode_state = ST_PDOWN;
            MODE_STBY:  mode_state = ST_STBY;
            default:    mode_ok    = 1'b0;
        endcase
    end
endmodule

// File: rtl/slpc_wake_filter.sv
module slpc_wake_filter
    import slpc_pkg::*;
(
    input  slpc_state_e     state,
    input  logic [WK_N-1:0] events,
    output logic            wake
);
    logic [WK_N-1:0] allow;

    always_comb begin
        allow = '0;
        unique case (state)
            ST_IDLE:  allow = '1;
            ST_ADCNR: begin
                allow[WK_WDT]   = 1'b1;
                allow[WK_EXT]   = 1'b1;
                allow[WK_PCINT] = 1'b1;
                allow[WK_ADC]   = 1'b1;
            end
            ST_PDOWN, ST_STBY: begin
                allow[WK_WDT]   = 1'b1;
                allow[WK_EXT]   = 1'b1;
                allow[WK_PCINT] = 1'b1;
            end
            default: allow = '0;
        endcase
    end

    assign wake = |(allow & events);
endmodule

// File: rtl/slpc_periph_gate.sv
module slpc_periph_gate #(
    parameter int NPERIPH = 4,
    parameter int DW      = 8,
    localparam int SEL_W  = (NPERIPH > 1) ? $clog2(NPERIPH) : 1
) (
    input  logic                  io_run,
    input  logic [NPERIPH-1:0]    prr,
    input  logic [SEL_W-1:0]      bus_sel,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [NPERIPH*DW-1:0] periph_rdata,
    output logic [NPERIPH-1:0]    periph_clk_en,
    output logic [NPERIPH-1:0]    periph_wr,
    output logic [DW-1:0]         bus_rdata
);
    logic [NPERIPH-1:0] rd_hit;

    for (genvar g = 0; g < NPERIPH; g++) begin : g_per
        logic sel_me;
        assign sel_me           = (32'(bus_sel) == g);
        assign periph_clk_en[g] = io_run & ~prr[g];
        assign periph_wr[g]     = bus_wr & sel_me & periph_clk_en[g];
        assign rd_hit[g]        = bus_rd & sel_me & periph_clk_en[g];
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NPERIPH; i++) begin
            if (rd_hit[i]) bus_rdata = periph_rdata[i*DW +: DW];
        end
    end
endmodule

// File: rtl/slpc_ctrl.sv
module slpc_ctrl
    import slpc_pkg::*;
#(
    parameter int NPERIPH   = 4,
    parameter int DW        = 8,
    parameter int OSC_START = 16,
    localparam int SEL_W    = (NPERIPH > 1) ? $clog2(NPERIPH) : 1,
    localparam int CNT_W    = $clog2(OSC_START + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sleep_en,
    input  logic                  sleep_pulse,
    input  logic [2:0]            mode_sel,
    input  logic                  wake_wdt,
    input  logic                  wake_ext,
    input  logic                  wake_pcint,
    input  logic                  wake_adc,
    input  logic                  wake_other,
    input  logic                  adc_enabled,
    input  logic                  acomp_req,
    input  logic [NPERIPH-1:0]    prr,
    input  logic [SEL_W-1:0]      bus_sel,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [NPERIPH*DW-1:0] periph_rdata,
    output logic                  cpu_clk_en,
    output logic                  io_clk_en,
    output logic                  nvm_clk_en,
    output logic                  adc_clk_en,
    output logic                  osc_en,
    output logic                  acomp_en,
    output logic                  adc_start,
    output logic [NPERIPH-1:0]    periph_clk_en,
    output logic [NPERIPH-1:0]    periph_wr,
    output logic [DW-1:0]         bus_rdata,
    output logic                  asleep
);
    slpc_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             start_q;
    logic             mode_ok, wake;
    slpc_state_e      mode_state;
    logic [WK_N-1:0]  events;
    logic             io_run;

    assign events[WK_WDT]   = wake_wdt;
    assign events[WK_EXT]   = wake_ext;
    assign events[WK_PCINT] = wake_pcint;
    assign events[WK_ADC]   = wake_adc;
    assign events[WK_OTHER] = wake_other;

    slpc_mode_decode u_dec (
        .mode_sel   (mode_sel),
        .mode_ok    (mode_ok),
        .mode_state (mode_state)
    );

    slpc_wake_filter u_wake (
        .state  (state_q),
        .events (events),
        .wake   (wake)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_ACTIVE:
                if (sleep_pulse && sleep_en && mode_ok) state_d = mode_state;
            ST_IDLE, ST_ADCNR, ST_STBY:
                if (wake) state_d = ST_ACTIVE;
            ST_PDOWN:
                if (wake) begin
                    state_d = ST_OSCWAIT;
                    cnt_d   = CNT_W'(OSC_START - 1);
                end
            ST_OSCWAIT:
                if (cnt_q == '0) state_d = ST_ACTIVE;
                else             cnt_d   = cnt_q - 1'b1;
            default: state_d = ST_ACTIVE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ACTIVE;
            cnt_q   <= '0;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            start_q <= (state_q != ST_ADCNR) && (state_d == ST_ADCNR) && adc_enabled;
        end
    end

    // Output decode
    always_comb begin
        cpu_clk_en = 1'b0;
        io_clk_en  = 1'b0;
        nvm_clk_en = 1'b0;
        adc_clk_en = 1'b0;
        osc_en     = 1'b0;
        io_run     = 1'b0;
        acomp_en   = acomp_req;
        unique case (state_q)
            ST_ACTIVE: begin
                cpu_clk_en = 1'b1;
                io_clk_en  = 1'b1;
                nvm_clk_en = 1'b1;
                adc_clk_en = 1'b1;
                osc_en     = 1'b1;
                io_run     = 1'b1;
            end
            ST_IDLE: begin
                io_clk_en  = 1'b1;
                adc_clk_en = 1'b1;
                osc_en     = 1'b1;
                io_run     = 1'b1;
            end
            ST_ADCNR: begin
                adc_clk_en = 1'b1;
                osc_en     = 1'b1;
            end
            ST_STBY: osc_en = 1'b1;
            ST_PDOWN: acomp_en = 1'b0;
            ST_OSCWAIT: begin
                osc_en   = 1'b1;
                acomp_en = 1'b0;
            end
            default: acomp_en = 1'b0;
        endcase
    end

    assign adc_start = start_q;
    assign asleep    = (state_q != ST_ACTIVE);

    slpc_periph_gate #(.NPERIPH(NPERIPH), .DW(DW)) u_pgate (
        .io_run        (io_run),
        .prr           (prr),
        .bus_sel       (bus_sel),
        .bus_wr        (bus_wr),
        .bus_rd        (bus_rd),
        .periph_rdata  (periph_rdata),
        .periph_clk_en (periph_clk_en),
        .periph_wr     (periph_wr),
        .bus_rdata     (bus_rdata)
    );
endmodule

// File: rtl/slpc_ctrl_chk.sv
module slpc_ctrl_chk
    import slpc_pkg::*;
#(
    parameter int NPERIPH = 4
) (
    input logic               clk,
    input logic               rst_n,
    input slpc_state_e        state_q,
    input logic               wake_wdt,
    input logic               wake_ext,
    input logic               wake_pcint,
    input logic               cpu_clk_en,
    input logic               io_clk_en,
    input logic               adc_clk_en,
    input logic               osc_en,
    input logic               acomp_en,
    input logic               adc_start,
    input logic               asleep,
    input logic [NPERIPH-1:0] periph_clk_en,
    input logic [NPERIPH-1:0] periph_wr
);
    // R1, R7: the CPU never runs without the oscillator
    p_cpu_needs_osc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en |-> osc_en);

    // R1: asleep and the CPU clock are complementary
    p_asleep_cpu_r1: assert property (@(posedge clk) disable iff (!rst_n)
        asleep != cpu_clk_en);

    // R3: start request lasts a single cycle
    p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    // R3: start request only while the ADC runs and the CPU is halted
    p_start_ctx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> (adc_clk_en && !cpu_clk_en));

    // R10: no write reaches a gated peripheral
    p_wr_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_wr & ~periph_clk_en) == '0);

    // R11: peripheral clocks only when the I/O clock runs
    p_pclk_io_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_clk_en != '0) |-> io_clk_en);

    // R12: comparator off whenever the oscillator is off
    p_acomp_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !acomp_en);

    // R6: power-down without an accepted event stays dark
    p_pd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PDOWN && !wake_wdt && !wake_ext && !wake_pcint)
            |=> (!osc_en && !cpu_clk_en));
endmodule

bind slpc_ctrl slpc_ctrl_chk #(.NPERIPH(NPERIPH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .state_q       (state_q),
    .wake_wdt      (wake_wdt),
    .wake_ext      (wake_ext),
    .wake_pcint    (wake_pcint),
    .cpu_clk_en    (cpu_clk_en),
    .io_clk_en     (io_clk_en),
    .adc_clk_en    (adc_clk_en),
    .osc_en        (osc_en),
    .acomp_en      (acomp_en),
    .adc_start     (adc_start),
    .asleep        (asleep),
    .periph_clk_en (periph_clk_en),
    .periph_wr     (periph_wr)
);

// File: tb/slpc_ctrl_tb_top.sv
module slpc_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP  = 4;
    localparam int DW  = 8;
    localparam int OSC = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_en = 1'b0, sleep_pulse = 1'b0;
    logic [2:0] mode_sel = 3'b000;
    logic wake_wdt = 0, wake_ext = 0, wake_pcint = 0, wake_adc = 0, wake_other = 0;
    logic adc_enabled = 0, acomp_req = 1;
    logic [NP-1:0] prr = '0;
    logic [1:0] bus_sel = '0;
    logic bus_wr = 0, bus_rd = 0;
    logic [NP*DW-1:0] periph_rdata = 32'h44332211;
    logic cpu_clk_en, io_clk_en, nvm_clk_en, adc_clk_en, osc_en, acomp_en, adc_start, asleep;
    logic [NP-1:0] periph_clk_en, periph_wr;
    logic [DW-1:0] bus_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    slpc_ctrl #(.NPERIPH(NP), .DW(DW), .OSC_START(OSC)) dut_i (.*);

    typedef struct {
        string       req;
        logic [23:0] exp;
        logic [23:0] msk;
    } item_t;

    item_t q[$];
    event  chk_ev;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    localparam logic [23:0] M_CLK  = 24'hFF0000;
    localparam logic [23:0] M_PCLK = 24'h00F000;
    localparam logic [23:0] M_BUS  = 24'h000FFF;

    function automatic logic [23:0] snap();
        return {asleep, cpu_clk_en, io_clk_en, nvm_clk_en, adc_clk_en, osc_en,
                acomp_en, adc_start, periph_clk_en, periph_wr, bus_rdata};
    endfunction

    function automatic logic [23:0] mk(bit a, bit c, bit i, bit n, bit d, bit o, bit k, bit s);
        return {a, c, i, n, d, o, k, s, 16'h0};
    endfunction

    // Monitor: pops expected items and compares them with the outputs
    always @(chk_ev) begin
        while (q.size() > 0) begin
            item_t it;
            logic [23:0] act;
            it  = q.pop_front();
            act = snap() & it.msk;
            checks++;
            if (act !== (it.exp & it.msk)) begin
                errors++;
                $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp & it.msk);
            end
        end
    end

    task automatic expect_v(string req, logic [23:0] exp, logic [23:0] msk);
        item_t it;
        it.req = req; it.exp = exp; it.msk = msk;
        q.push_back(it);
        -> chk_ev;
        #1;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic sleep_cmd(logic [2:0] m);
        mode_sel = m;
        sleep_pulse = 1'b1;
        step();
        sleep_pulse = 1'b0;
    endtask

    localparam logic [23:0] E_ACT  = 24'h7E0000;  // active, comparator on
    localparam logic [23:0] E_IDLE = 24'hAE0000;
    localparam logic [23:0] E_PD   = 24'h800000;
    localparam logic [23:0] E_OSCW = 24'h840000;
    localparam logic [23:0] E_SB   = 24'h860000;

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        expect_v("R1 reset active", E_ACT | 24'h00F000, M_CLK | M_PCLK);

        // R9: sleep pulse without enable
        sleep_en = 1'b0;
        sleep_cmd(3'b000);
        expect_v("R9 no enable", E_ACT, M_CLK);
        // R9: unused encoding
        sleep_en = 1'b1;
        sleep_cmd(3'b011);
        expect_v("R9 bad mode 011", E_ACT, M_CLK);
        sleep_cmd(3'b111);
        expect_v("R9 bad mode 111", E_ACT, M_CLK);

        // R2 idle, R11 prr applies in idle
        prr = 4'b0010;
        sleep_cmd(3'b000);
        expect_v("R2 idle enables", E_IDLE, M_CLK);
        expect_v("R11 idle prr gating", 24'h00D000, M_PCLK);
        wake_other = 1'b1; step(); wake_other = 1'b0;
        expect_v("R2 idle wake by other", E_ACT, M_CLK);

        // R10 access blocking
        bus_sel = 2'd1; bus_wr = 1'b1; bus_rd = 1'b1;
        step();
        expect_v("R10 gated write and read", 24'h00D000, M_PCLK | M_BUS);
        bus_sel = 2'd2;
        step();
        expect_v("R10 ungated access", 24'h00D433, M_PCLK | M_BUS);
        prr = 4'b0000; bus_sel = 2'd1;
        step();
        expect_v("R10 restored after clear", 24'h00F222, M_PCLK | M_BUS);
        bus_wr = 1'b0; bus_rd = 1'b0;

        // R3 noise reduction with ADC enabled
        adc_enabled = 1'b1;
        sleep_cmd(3'b001);
        expect_v("R3 nr entry with start", 24'h8E0000 | 24'h010000, M_CLK);
        expect_v("R11 nr peripherals off", 24'h000000, M_PCLK);
        step();
        expect_v("R3 start one cycle", 24'h8E0000, M_CLK);
        wake_other = 1'b1; step(); wake_other = 1'b0;
        expect_v("R4 nr ignores other", 24'h8E0000, M_CLK);
        sleep_cmd(3'b000);
        expect_v("R9 pulse while asleep", 24'h8E0000, M_CLK);
        wake_adc = 1'b1; step(); wake_adc = 1'b0;
        expect_v("R4 nr wake by adc", E_ACT, M_CLK);

        // R3 without ADC enabled
        adc_enabled = 1'b0;
        sleep_cmd(3'b001);
        expect_v("R3 nr no start", 24'h8E0000, M_CLK);
        wake_pcint = 1'b1; step(); wake_pcint = 1'b0;
        expect_v("R4 nr wake by pcint", E_ACT, M_CLK);

        // R5 power-down
        sleep_cmd(3'b010);
        expect_v("R5 pd all off", E_PD, M_CLK | M_PCLK);
        wake_adc = 1'b1; step(); wake_adc = 1'b0;
        expect_v("R6 pd ignores adc", E_PD, M_CLK);
        wake_other = 1'b1; step(); wake_other = 1'b0;
        expect_v("R6 pd ignores other", E_PD, M_CLK);
        wake_ext = 1'b1; step(); wake_ext = 1'b0;
        expect_v("R7 oscwait begins", E_OSCW, M_CLK);
        expect_v("R12 acomp off in wait", E_OSCW, M_CLK);
        repeat (OSC - 1) step();
        expect_v("R7 still waiting", E_OSCW, M_CLK);
        step();
        expect_v("R7 clocks back", E_ACT, M_CLK);

        // R8 standby
        sleep_cmd(3'b100);
        expect_v("R8 standby osc on", E_SB, M_CLK);
        wake_wdt = 1'b1; step(); wake_wdt = 1'b0;
        expect_v("R8 standby fast wake", E_ACT, M_CLK);

        // R12 comparator follows request when active
        acomp_req = 1'b0;
        step();
        expect_v("R12 acomp follows req", 24'h7C0000, M_CLK);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule